// File: doc/BRIEF.md
# Dirty Line Write-Back Buffer

This block sits between a data cache controller and external memory. When the controller evicts a modified line, it hands the whole line to this buffer in a single cycle. The line is four 32-bit words, given with the miss address that caused the eviction. The buffer keeps the line and its line address. When the memory port is free it writes the line out as four single-word writes, and the cache carries on serving the CPU meanwhile.

A line fill for the miss that caused the eviction has first claim on the memory port. While the controller holds `fill_active` high, the buffer waits and issues no memory writes. It starts the drain only once the fill has ended. The four writes go out in wrap-around order, beginning at the word the miss address points to. Each write advances only when memory signals ready. The buffer holds one line only, so the controller must hold back a second eviction until `empty` returns high.

Top module: `evict_line_buffer`

## Requirements
- R1: After reset `busy` is 0, `empty` is 1, `ld_ready` is 1 and `mem_valid` is 0.
- R2: A load is taken at a clock edge where `ld_valid` and `ld_ready` are both 1. From the next cycle on, `busy` is 1, `empty` is 0 and `ld_ready` is 0.
- R3: While `busy` is 1, `ld_valid` is ignored. The drained words and addresses stay those of the line already held.
- R4: The buffer waits after a load. At each clock edge where `fill_active` is 1, `mem_valid` stays 0 for the next cycle. The first edge in the waiting state that samples `fill_active` at 0 raises `mem_valid` in the following cycle.
- R5: The word index of the first write is `ld_addr[3:2]` of the load. Each accepted write advances the index by 1 modulo 4, for example 1, 2, 3, 0.
- R6: `mem_addr` equals {3'b000, stored `ld_addr[28:4]`, word index, 2'b00}. The top three address bits are always 0.
- R7: `mem_data` is the stored word with the current index. Word i of a load is `ld_line[32*i+31 : 32*i]`.
- R8: A write is accepted at an edge where `mem_valid` and `mem_ready` are both 1. While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr` and `mem_data` hold their values.
- R9: In the cycle after the fourth write is accepted, `busy` is 0, `empty` is 1, `ld_ready` is 1 and `mem_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Controller offers an evicted line |
| ld_ready | output | 1 | Buffer can take a line |
| ld_addr | input | 32 | Miss address: line address and starting word |
| ld_line | input | 128 | Evicted line, word i in bits 32*i+31:32*i |
| fill_active | input | 1 | A line fill owns the memory port |
| mem_valid | output | 1 | Write request to memory |
| mem_ready | input | 1 | Memory accepts the current write |
| mem_addr | output | 32 | Byte address of the current word |
| mem_data | output | 32 | Data of the current word |
| busy | output | 1 | Buffer holds a line not yet written |
| empty | output | 1 | Buffer holds no line |

## Verification
A load shows on `busy`, `empty` and `ld_ready` one edge after it is taken. The first write appears one edge after the first waiting-state edge that samples `fill_active` low, so the earliest is two edges after the load. Each accepted write changes address and data one edge later. The status returns to empty one edge after the fourth accepted write. The bench drives inputs on falling edges and reads outputs just before the next rising edge. It walks through the loop one cycle at a time and predicts each value from the number of accepted writes and the fill cycles it has driven. It sweeps every start word, several fill lengths and several ready patterns.

// File: rtl/evict_pkg.sv
package evict_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_DRAIN = 2'd2
  } evict_state_t;
endpackage

// File: rtl/evict_store.sv
module evict_store #(
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 25,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic                      clk,
  input  logic                      we,
  input  logic [WORD_W*WORDS-1:0]   line_in,
  input  logic [TAG_W-1:0]          tag_in,
  input  logic [IDX_W-1:0]          rd_idx,
  output logic [WORD_W-1:0]         rd_word,
  output logic [TAG_W-1:0]          tag_q
);
  logic [WORD_W-1:0] words_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (we) words_q[g] <= line_in[g*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (we) tag_q <= tag_in;
  end

  assign rd_word = words_q[rd_idx];
endmodule

// File: rtl/evict_seq.sv
module evict_seq
  import evict_pkg::*;
#(
  parameter int WORDS  = 4,
  localparam int IDX_W = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_valid,
  input  logic [IDX_W-1:0] ld_start,
  input  logic             fill_active,
  input  logic             mem_ready,
  output logic             take,
  output logic             busy,
  output logic             mem_valid,
  output logic [IDX_W-1:0] idx
);
  evict_state_t     state_q;
  logic [IDX_W-1:0] start_q;
  logic [IDX_W-1:0] cnt_q;
  logic             beat;
  logic             last;

  assign take = ld_valid && (state_q == ST_IDLE);
  assign beat = (state_q == ST_DRAIN) && mem_ready;
  assign last = (cnt_q == IDX_W'(WORDS - 1));
  assign idx  = start_q + cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      start_q   <= '0;
      cnt_q     <= '0;
      busy      <= 1'b0;
      mem_valid <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (take) begin
            state_q <= ST_WAIT;
            start_q <= ld_start;
            cnt_q   <= '0;
            busy    <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (!fill_active) begin
            state_q   <= ST_DRAIN;
            mem_valid <= 1'b1;
          end
        end
        ST_DRAIN: begin
          if (beat) begin
            if (last) begin
              state_q   <= ST_IDLE;
              busy      <= 1'b0;
              mem_valid <= 1'b0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/evict_line_buffer.sv
module evict_line_buffer #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int ZERO_HI = 3,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int BOFF   = $clog2(WORD_W / 8),
  localparam int LINE_W = ADDR_W - IDX_W - BOFF,
  localparam int TAG_W  = LINE_W - ZERO_HI
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_valid,
  output logic                    ld_ready,
  input  logic [ADDR_W-1:0]       ld_addr,
  input  logic [WORD_W*WORDS-1:0] ld_line,
  input  logic                    fill_active,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [WORD_W-1:0]       mem_data,
  output logic                    busy,
  output logic                    empty
);
  logic             take;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag_q;

  evict_seq #(.WORDS(WORDS)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .ld_valid    (ld_valid),
    .ld_start    (ld_addr[BOFF +: IDX_W]),
    .fill_active (fill_active),
    .mem_ready   (mem_ready),
    .take        (take),
    .busy        (busy),
    .mem_valid   (mem_valid),
    .idx         (idx)
  );

  evict_store #(.WORD_W(WORD_W), .WORDS(WORDS), .TAG_W(TAG_W)) u_store (
    .clk     (clk),
    .we      (take),
    .line_in (ld_line),
    .tag_in  (ld_addr[BOFF + IDX_W +: TAG_W]),
    .rd_idx  (idx),
    .rd_word (mem_data),
    .tag_q   (tag_q)
  );

  assign mem_addr = {{ZERO_HI{1'b0}}, tag_q, idx, {BOFF{1'b0}}};
  assign ld_ready = !busy;
  assign empty    = !busy;
endmodule

// File: rtl/evict_line_buffer_chk.sv
module evict_line_buffer_chk #(
  parameter int ADDR_W  = 32,
  parameter int WORD_W  = 32,
  parameter int WORDS   = 4,
  parameter int ZERO_HI = 3,
  localparam int IDX_W  = $clog2(WORDS),
  localparam int BOFF   = $clog2(WORD_W / 8)
) (
  input logic              clk,
  input logic              rst,
  input logic              ld_valid,
  input logic              ld_ready,
  input logic              fill_active,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [WORD_W-1:0] mem_data,
  input logic              busy
);
  // R2
  load_sets_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && ld_ready) |=> busy);
  // R3
  busy_refuses_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !ld_ready);
  // R4
  fill_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (fill_active && !mem_valid) |=> !mem_valid);
  // R5
  wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready) |=> (!mem_valid ||
      mem_addr[BOFF +: IDX_W] == IDX_W'($past(mem_addr[BOFF +: IDX_W]) + 1'b1)));
  // R6
  high_zero_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr[ADDR_W-1 -: ZERO_HI] == '0));
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
  // R9
  valid_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> busy);
endmodule

bind evict_line_buffer evict_line_buffer_chk #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS(WORDS), .ZERO_HI(ZERO_HI)
) u_chk (
  .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
  .fill_active(fill_active), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .busy(busy)
);

// File: tb/test_evict_line_buffer.sv
module test_evict_line_buffer;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         ld_valid = 1'b0;
  logic         ld_ready;
  logic [31:0]  ld_addr = '0;
  logic [127:0] ld_line = '0;
  logic         fill_active = 1'b0;
  logic         mem_valid;
  logic         mem_ready = 1'b0;
  logic [31:0]  mem_addr;
  logic [31:0]  mem_data;
  logic         busy;
  logic         empty;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  evict_line_buffer i_evict_line_buffer (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_line(ld_line), .fill_active(fill_active),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy), .empty(empty)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic ready_pat(input int p, input int c);
    if (p == 0) return 1'b1;
    if (p == 1) return (c % 2) == 1;
    return (c % 3) == 2;
  endfunction

  task automatic run(input int run_id, input int off, input int fill_n, input int p);
    logic [31:0] a;
    logic [31:0] w [4];
    int b;
    int c;
    a = (32'hF234_5670 ^ (run_id << 8) ^ (run_id << 20)) & 32'hFFFF_FFF0;
    a = a | (off << 2) | (run_id & 3);
    for (int i = 0; i < 4; i++) w[i] = 32'hA000_0000 + (run_id << 8) + i;
    // load at the next rising edge
    ld_valid = 1'b1;
    ld_addr = a;
    ld_line = {w[3], w[2], w[1], w[0]};
    fill_active = (fill_n > 0);
    @(negedge clk);
    chk("R2 busy", {31'b0, busy}, 32'd1);
    chk("R2 empty", {31'b0, empty}, 32'd0);
    chk("R2 ld_ready", {31'b0, ld_ready}, 32'd0);
    // R3: a different line offered while busy
    ld_addr = ~a;
    ld_line = ~{w[3], w[2], w[1], w[0]};
    for (int k = 0; k < fill_n; k++) begin
      fill_active = 1'b1;
      @(negedge clk);
      chk("R4 held by fill", {31'b0, mem_valid}, 32'd0);
    end
    fill_active = 1'b0;
    @(negedge clk);
    chk("R4 drain starts", {31'b0, mem_valid}, 32'd1);
    ld_valid = 1'b0;
    b = 0;
    c = 0;
    while (b < 4) begin
      logic r;
      int ix;
      ix = (off + b) % 4;
      chk("R8 valid", {31'b0, mem_valid}, 32'd1);
      chk("R5 R6 addr", mem_addr, {3'b000, a[28:4], ix[1:0], 2'b00});
      chk("R3 R7 data", mem_data, w[ix]);
      r = ready_pat(p, c);
      mem_ready = r;
      @(negedge clk);
      c++;
      if (r) b++;
    end
    mem_ready = 1'b0;
    chk("R9 busy", {31'b0, busy}, 32'd0);
    chk("R9 empty", {31'b0, empty}, 32'd1);
    chk("R9 ld_ready", {31'b0, ld_ready}, 32'd1);
    chk("R9 mem_valid", {31'b0, mem_valid}, 32'd0);
  endtask

  initial begin
    int id;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 empty", {31'b0, empty}, 32'd1);
    chk("R1 ld_ready", {31'b0, ld_ready}, 32'd1);
    chk("R1 mem_valid", {31'b0, mem_valid}, 32'd0);
    id = 0;
    for (int off = 0; off < 4; off++)
      for (int f = 0; f < 3; f++)
        for (int p = 0; p < 3; p++) begin
          run(id, off, (f == 2) ? 3 : f, p);
          id++;
        end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule